// File: doc/BRIEF.md
# Boolean Pattern Match Engine

This block watches eight input lines and raises an interrupt when a programmable sum-of-products expression over them becomes true. Eight bit slices are the building blocks. Each slice picks one of the eight lines and applies a condition to it: a level, an inverted level, a held edge, a one-cycle edge event, or a constant. Neighbouring slices are ANDed into a product term until a slice marked as a term end is reached. All completed terms are ORed into the result. This gives expressions such as IN0·~IN1·IN3 + IN1·IN2 + IN0·~IN3·~IN4 without any processor involvement.

The same eight lines can instead drive a plain per-line interrupt generator. In that mode, enabled rising or falling edges set per-line pending bits, and the interrupt is the OR of those bits. One mode bit picks between the two functions, and they never act together. Software programs the engine through a simple write port: a write strobe, a 3-bit address and a 24-bit data word.

Top module: `pmatch_engine`

## Requirements
- R1: After reset, `match_o` and `irq_o` are 0. The engine is in per-line mode with both edge-enable masks at zero, so activity on `pins_i` raises no interrupt. Every slice holds code 6 (constant low) and selects input line equal to its own index. No slice carries a term-end mark.
- R2: Each line passes through two synchronizing flops, and `match_o` is a register. A level applied to `pins_i` before rising edge k is first visible on `match_o` (and on a per-line `irq_o`) after edge k+2, and not after edge k+1.
- R3: Address 1 holds one 3-bit condition code per slice, with slice i at data bits [3i+2:3i]. Code 0 is always true. Code 1 is a held rising edge. Code 2 is a held falling edge. Code 3 is a held edge of either direction. Code 4 is true while the line is high. Code 5 is true while the line is low. Code 6 is never true. Code 7 is true only during the single cycle in which an edge of either direction is detected.
- R4: Slices are ANDed in index order into a product term. A slice whose bit is set in address 2 (data bits [7:0]) closes the term. Slice 7 always closes a term. `match_o` is the OR of all closed terms.
- R5: A held edge stays true until one of two things happens. Either a write to address 3 sets that slice's bit in data [7:0], or a write to address 0, 1, 2 or 5 clears every held edge.
- R6: If an edge is detected in the same cycle as a clear for that slice through address 3, the edge wins: the held flag stays set.
- R7: With code 7, a single edge makes `match_o` high for exactly one cycle.
- R8: In pattern mode, `irq_o` pulses high for one cycle when `match_o` goes from 0 to 1, in the same cycle as that rise, and stays low while `match_o` stays high.
- R9: In per-line mode (address 0, data bit 0 = 0), `match_o` stays 0. An edge on line i sets a pending bit if that edge is enabled: rising edges are enabled by address 4 data bit i, and falling edges by data bit 8+i. `irq_o` is the OR of the pending bits. Writing address 3 with data bit i set clears pending bit i one cycle later.
- R10: Address 0 data bit 0 = 1 selects pattern mode. In that mode no pending bit is ever set, whatever the edge enables hold. Any write to address 0 clears all pending bits.
- R11: Address 5 holds a 3-bit source select per slice, with slice i at data bits [3i+2:3i]. A slice evaluates only the line it selects, so changes on other lines do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Monitored lines, asynchronous to clk |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 24 | Configuration write data |
| irq_o | output | 1 | Interrupt: one-cycle pulse in pattern mode, pending level in per-line mode |
| match_o | output | 1 | Registered value of the sum-of-products expression |

## Verification
The critical collision is between edge detection on a line and a software clear of the same slice's held flag. The bench provokes it by raising line 0 under code 1 and timing a clear write to address 3 so that it lands on exactly the edge at which the synchronized rise is seen. It judges the result by requiring `match_o` to rise and stay high afterwards. A control run, in which the clear arrives well after the edge, must drop `match_o`. Mode switching against live edge enables, and a level-change pattern sweep against an independently computed expression, cover the other interactions.

// File: rtl/pme_pkg.sv
package pme_pkg;

    // Slice condition codes (encoding is visible to software)
    typedef enum logic [2:0] {
        COND_ONE     = 3'd0,
        COND_RISE_ST = 3'd1,
        COND_FALL_ST = 3'd2,
        COND_EDGE_ST = 3'd3,
        COND_HIGH    = 3'd4,
        COND_LOW     = 3'd5,
        COND_ZERO    = 3'd6,
        COND_EVENT   = 3'd7
    } cond_e;

    localparam int unsigned COND_W = 3;

    // Configuration register addresses
    localparam int unsigned ADDR_CTRL  = 0;
    localparam int unsigned ADDR_COND  = 1;
    localparam int unsigned ADDR_ENDP  = 2;
    localparam int unsigned ADDR_CLR   = 3;
    localparam int unsigned ADDR_PINEN = 4;
    localparam int unsigned ADDR_SRC   = 5;

endpackage

// File: rtl/pme_sync.sv
module pme_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
        logic [WIDTH-1:0] prev;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pins_i;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl_o  = s_q.sync;
    assign rise_o = s_q.sync & ~s_q.prev;
    assign fall_o = ~s_q.sync & s_q.prev;

    // Two flops between a pin and the level used by the slices
    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rst_n, 2) |-> lvl_o == $past(pins_i, 2));

endmodule

// File: rtl/pme_slice.sv
module pme_slice
    import pme_pkg::*;
#(
    parameter int unsigned NUM_IN = 8,
    parameter int unsigned SRC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COND_W-1:0] cond_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [NUM_IN-1:0] lvl_i,
    input  logic [NUM_IN-1:0] rise_i,
    input  logic [NUM_IN-1:0] fall_i,
    input  logic              swclr_i,
    input  logic              rewrite_i,
    output logic              val_o
);

    typedef struct packed {
        logic held;
    } slice_state_t;

    slice_state_t s_d, s_q;
    logic lvl_sel, rise_sel, fall_sel, edge_hit;

    always_comb begin
        lvl_sel  = lvl_i[src_i];
        rise_sel = rise_i[src_i];
        fall_sel = fall_i[src_i];
        edge_hit = 1'b0;
        val_o    = 1'b0;
        unique case (cond_e'(cond_i))
            COND_ONE:     val_o = 1'b1;
            COND_RISE_ST: edge_hit = rise_sel;
            COND_FALL_ST: edge_hit = fall_sel;
            COND_EDGE_ST: edge_hit = rise_sel | fall_sel;
            COND_HIGH:    val_o = lvl_sel;
            COND_LOW:     val_o = ~lvl_sel;
            COND_ZERO:    val_o = 1'b0;
            COND_EVENT:   val_o = rise_sel | fall_sel;
            default:      val_o = 1'b0;
        endcase
        if (cond_i == COND_RISE_ST || cond_i == COND_FALL_ST || cond_i == COND_EDGE_ST)
            val_o = s_q.held | edge_hit;

        s_d = s_q;
        if (rewrite_i) s_d.held = 1'b0;
        else           s_d.held = (s_q.held & ~swclr_i) | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_held_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_q.held) && !$past(swclr_i) && !$past(rewrite_i) |-> s_q.held);

    assert_edge_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit && swclr_i && !rewrite_i |=> s_q.held);

endmodule

// File: rtl/pme_chain.sv
module pme_chain #(
    parameter int unsigned NUM_IN = 8
) (
    input  logic [NUM_IN-1:0] val_i,
    input  logic [NUM_IN-1:0] ep_i,
    output logic              hit_o
);

    logic [NUM_IN:0] prod;
    logic [NUM_IN:0] acc;

    // Running AND restarts after every closing slice; the last slice always closes
    always_comb begin
        prod[0] = 1'b1;
        acc[0]  = 1'b0;
        for (int k = 0; k < NUM_IN; k++) begin
            if (ep_i[k] || k == NUM_IN - 1) begin
                acc[k+1]  = acc[k] | (prod[k] & val_i[k]);
                prod[k+1] = 1'b1;
            end else begin
                acc[k+1]  = acc[k];
                prod[k+1] = prod[k] & val_i[k];
            end
        end
        hit_o = acc[NUM_IN];
    end

endmodule

// File: rtl/pmatch_engine.sv
module pmatch_engine
    import pme_pkg::*;
#(
    parameter int unsigned NUM_IN = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IN-1:0]        pins_i,
    input  logic                     cfg_we_i,
    input  logic [ADDR_W-1:0]        cfg_addr_i,
    input  logic [NUM_IN*COND_W-1:0] cfg_wdata_i,
    output logic                     irq_o,
    output logic                     match_o
);

    localparam int unsigned SRC_W  = $clog2(NUM_IN);
    localparam int unsigned DATA_W = NUM_IN * COND_W;

    typedef struct packed {
        logic                               mode;
        logic [NUM_IN-1:0][COND_W-1:0]      cond;
        logic [NUM_IN-1:0][SRC_W-1:0]       src;
        logic [NUM_IN-1:0]                  endp;
        logic [NUM_IN-1:0]                  rise_en;
        logic [NUM_IN-1:0]                  fall_en;
        logic [NUM_IN-1:0]                  pend;
        logic                               match;
        logic                               irq;
    } eng_state_t;

    function automatic eng_state_t reset_state();
        eng_state_t r;
        r = '0;
        for (int k = 0; k < NUM_IN; k++) begin
            r.cond[k] = COND_W'(COND_ZERO);
            r.src[k]  = SRC_W'(k);
        end
        return r;
    endfunction

    localparam eng_state_t RST_STATE = reset_state();

    eng_state_t s_d, s_q;

    logic [NUM_IN-1:0] lvl, rise, fall;
    logic [NUM_IN-1:0] slice_val;
    logic [NUM_IN-1:0] swclr;
    logic [NUM_IN-1:0] pend_clr, pend_set;
    logic              rewrite;
    logic              expr_hit;
    logic              wr_ctrl, wr_cond, wr_endp, wr_clr, wr_pinen, wr_src;

    pme_sync #(.WIDTH(NUM_IN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    for (genvar g = 0; g < NUM_IN; g++) begin : g_slice
        pme_slice #(.NUM_IN(NUM_IN), .SRC_W(SRC_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .cond_i    (s_q.cond[g]),
            .src_i     (s_q.src[g]),
            .lvl_i     (lvl),
            .rise_i    (rise),
            .fall_i    (fall),
            .swclr_i   (swclr[g]),
            .rewrite_i (rewrite),
            .val_o     (slice_val[g])
        );
    end

    pme_chain #(.NUM_IN(NUM_IN)) u_chain (
        .val_i (slice_val),
        .ep_i  (s_q.endp),
        .hit_o (expr_hit)
    );

    always_comb begin
        wr_ctrl  = cfg_we_i && (cfg_addr_i == ADDR_W'(ADDR_CTRL));
        wr_cond  = cfg_we_i && (cfg_addr_i == ADDR_W'(ADDR_COND));
        wr_endp  = cfg_we_i && (cfg_addr_i == ADDR_W'(ADDR_ENDP));
        wr_clr   = cfg_we_i && (cfg_addr_i == ADDR_W'(ADDR_CLR));
        wr_pinen = cfg_we_i && (cfg_addr_i == ADDR_W'(ADDR_PINEN));
        wr_src   = cfg_we_i && (cfg_addr_i == ADDR_W'(ADDR_SRC));

        rewrite  = wr_ctrl | wr_cond | wr_endp | wr_src;
        swclr    = wr_clr ? cfg_wdata_i[NUM_IN-1:0] : '0;

        s_d = s_q;
        if (wr_ctrl) s_d.mode = cfg_wdata_i[0];
        if (wr_cond) begin
            for (int k = 0; k < NUM_IN; k++)
                s_d.cond[k] = cfg_wdata_i[k*COND_W +: COND_W];
        end
        if (wr_endp) s_d.endp = cfg_wdata_i[NUM_IN-1:0];
        if (wr_pinen) begin
            s_d.rise_en = cfg_wdata_i[NUM_IN-1:0];
            s_d.fall_en = cfg_wdata_i[2*NUM_IN-1:NUM_IN];
        end
        if (wr_src) begin
            for (int k = 0; k < NUM_IN; k++)
                s_d.src[k] = cfg_wdata_i[k*SRC_W +: SRC_W];
        end

        // Per-line pending bits, only in per-line mode
        pend_clr = wr_ctrl ? '1 : swclr;
        pend_set = s_d.mode ? '0 : ((rise & s_q.rise_en) | (fall & s_q.fall_en));
        s_d.pend = (s_q.pend & ~pend_clr) | pend_set;

        // Pattern result and its rising-edge interrupt
        s_d.match = s_d.mode & expr_hit;
        s_d.irq   = s_d.mode & expr_hit & ~s_q.match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_STATE;
        else        s_q <= s_d;
    end

    assign match_o = s_q.match;
    assign irq_o   = s_q.mode ? s_q.irq : |s_q.pend;

    assert_match_needs_slice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.match |-> $past(|slice_val));

    assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.mode && irq_o |-> match_o && !$past(match_o));

    assert_line_mode_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.mode |-> !match_o);

    assert_pend_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        |(s_q.pend & ~$past(s_q.pend)) |->
            $past(|((rise & s_q.rise_en) | (fall & s_q.fall_en))));

    assert_pattern_no_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.mode |-> s_q.pend == '0);

endmodule

// File: tb/pmatch_engine_test.sv
module pmatch_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        irq_o;
    logic        match_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    m;
        bit    i;
        string tag;
    } exp_t;

    exp_t sb[$];

    pmatch_engine uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .irq_o       (irq_o),
        .match_o     (match_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expected item due in this cycle
    always @(negedge clk) begin
        for (int k = sb.size() - 1; k >= 0; k--) begin
            if (sb[k].at <= cyc) begin
                checks++;
                if (sb[k].at != cyc || match_o !== sb[k].m || irq_o !== sb[k].i) begin
                    errors++;
                    $display("FAIL %s: cycle %0d match=%0b irq=%0b, expected match=%0b irq=%0b at cycle %0d",
                             sb[k].tag, cyc, match_o, irq_o, sb[k].m, sb[k].i, sb[k].at);
                end
                sb.delete(k);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_at(input int off, input bit m, input bit i, input string tag);
        exp_t e;
        e.at = cyc + off; e.m = m; e.i = i; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic cfg(input logic [2:0] a, input logic [23:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    function automatic bit ex_eval(input logic [7:0] p);
        return (p[0] & ~p[1] & p[3]) | (p[1] & p[2]) | (p[0] & ~p[3] & ~p[4]);
    endfunction

    initial begin : driver
        bit prev;
        bit now;
        tick(4);
        rst_n = 1'b1;
        expect_at(1, 0, 0, "R1 reset outputs");
        expect_at(3, 0, 0, "R1 reset outputs");
        tick(4);
        pins = 8'hA5;
        expect_at(4, 0, 0, "R1 no edge enabled");
        tick(5);
        pins = 8'h00;
        tick(4);

        // Per-line mode
        cfg(3'd4, 24'h000004);
        pins[2] = 1'b1;
        expect_at(2, 0, 0, "R2 not yet visible");
        expect_at(3, 0, 1, "R9 rise pending");
        tick(4);
        pins[2] = 1'b0;
        expect_at(4, 0, 1, "R9 disabled fall keeps pending");
        tick(5);
        expect_at(1, 0, 0, "R9 clear pending");
        cfg(3'd3, 24'h000004);
        tick(2);
        cfg(3'd4, 24'h002000);
        pins[5] = 1'b1;
        expect_at(4, 0, 0, "R9 rise not enabled");
        tick(5);
        pins[5] = 1'b0;
        pins[2] = 1'b1;
        expect_at(3, 0, 1, "R9 fall pending");
        tick(4);
        expect_at(1, 0, 1, "R9 other bit kept");
        cfg(3'd3, 24'h000004);
        expect_at(1, 0, 0, "R9 clear own bit");
        cfg(3'd3, 24'h000020);
        pins = 8'h00;
        tick(4);

        // Pattern mode with a three-term expression
        cfg(3'd0, 24'h000001);
        cfg(3'd5, 24'o43021310);
        cfg(3'd2, 24'h000014);
        cfg(3'd1, 24'o55444454);
        tick(4);
        prev = 1'b0;
        for (int k = 0; k < 32; k++) begin
            pins = 8'(k);
            now = ex_eval(8'(k));
            expect_at(2, prev, 1'b0, "R2 old value held");
            expect_at(3, now, now & ~prev, "R4 R8 expression");
            expect_at(4, now, 1'b0, "R8 single pulse");
            tick(4);
            prev = now;
        end
        pins = 8'h00;
        tick(4);

        // Held rising edge, single slice per term
        cfg(3'd2, 24'h0000FF);
        cfg(3'd5, 24'o76543210);
        cfg(3'd1, 24'o66666661);
        tick(3);
        expect_at(1, 0, 0, "R3 held rise idle");
        tick(1);
        pins[0] = 1'b1;
        expect_at(2, 0, 0, "R2 latency");
        expect_at(3, 1, 1, "R3 held rise");
        expect_at(4, 1, 0, "R3 held rise");
        tick(4);
        pins[0] = 1'b0;
        expect_at(4, 1, 0, "R5 held after fall");
        tick(5);
        expect_at(2, 0, 0, "R5 software clear");
        cfg(3'd3, 24'h000001);
        tick(3);

        // Edge and clear in the same cycle
        pins[0] = 1'b1;
        tick(2);
        expect_at(1, 1, 1, "R6 edge wins");
        expect_at(4, 1, 0, "R6 edge wins");
        cfg(3'd3, 24'h000001);
        tick(4);
        pins[0] = 1'b0;
        tick(4);
        expect_at(1, 1, 0, "R5 before rewrite");
        expect_at(2, 0, 0, "R5 rewrite clears");
        cfg(3'd2, 24'h0000FF);
        tick(3);

        // Held falling edge
        cfg(3'd1, 24'o66666662);
        tick(2);
        pins[0] = 1'b1;
        expect_at(4, 0, 0, "R3 fall code ignores rise");
        tick(5);
        pins[0] = 1'b0;
        expect_at(3, 1, 1, "R3 held fall");
        expect_at(5, 1, 0, "R3 held fall");
        tick(6);

        // Held either edge
        cfg(3'd1, 24'o66666663);
        tick(2);
        pins[0] = 1'b1;
        expect_at(3, 1, 1, "R3 either edge rise");
        tick(5);
        expect_at(2, 0, 0, "R5 clear either");
        cfg(3'd3, 24'h000001);
        tick(3);
        pins[0] = 1'b0;
        expect_at(3, 1, 1, "R3 either edge fall");
        tick(5);

        // One-cycle event
        cfg(3'd1, 24'o66666667);
        tick(2);
        expect_at(1, 0, 0, "R7 idle");
        tick(1);
        pins[0] = 1'b1;
        expect_at(3, 1, 1, "R7 event");
        expect_at(4, 0, 0, "R7 one cycle only");
        tick(6);
        pins[0] = 1'b0;
        expect_at(3, 1, 1, "R7 event on fall");
        expect_at(4, 0, 0, "R7 one cycle only");
        tick(6);

        // Level and constant codes
        expect_at(2, 0, 0, "R3 high with line low");
        cfg(3'd1, 24'o66666664);
        tick(3);
        expect_at(2, 1, 1, "R3 low with line low");
        cfg(3'd1, 24'o66666665);
        tick(3);
        expect_at(2, 1, 0, "R3 constant high");
        cfg(3'd1, 24'o66666660);
        tick(3);
        expect_at(2, 0, 0, "R3 constant low");
        cfg(3'd1, 24'o66666666);
        tick(3);
        pins = 8'hFF;
        expect_at(4, 0, 0, "R3 constant low ignores lines");
        tick(5);
        pins = 8'h00;
        tick(4);

        // Source select
        cfg(3'd5, 24'o76543216);
        cfg(3'd1, 24'o66666664);
        tick(3);
        pins[0] = 1'b1;
        expect_at(4, 0, 0, "R11 unselected line");
        tick(5);
        pins[6] = 1'b1;
        expect_at(3, 1, 1, "R11 selected line");
        tick(5);
        pins = 8'h00;
        cfg(3'd5, 24'o76543210);
        tick(4);

        // One eight-slice term: slice 7 closes it
        cfg(3'd2, 24'h000000);
        cfg(3'd1, 24'o44444444);
        tick(3);
        pins = 8'hFF;
        expect_at(3, 1, 1, "R4 full product");
        tick(5);
        pins = 8'h7F;
        expect_at(3, 0, 0, "R4 one factor low");
        tick(5);
        pins = 8'h00;
        tick(4);

        // Mode exclusivity
        cfg(3'd2, 24'h0000FF);
        cfg(3'd1, 24'o66666666);
        cfg(3'd4, 24'h000008);
        pins[3] = 1'b1;
        expect_at(4, 0, 0, "R10 no pending in pattern mode");
        tick(5);
        pins[3] = 1'b0;
        tick(4);
        expect_at(2, 0, 0, "R10 switch to line mode");
        cfg(3'd0, 24'h000000);
        tick(3);
        pins[3] = 1'b1;
        expect_at(3, 0, 1, "R9 line mode edge");
        tick(5);
        expect_at(1, 0, 0, "R10 mode write clears pending");
        cfg(3'd0, 24'h000001);
        tick(6);

        if (sb.size() != 0) begin
            errors += sb.size();
            checks += sb.size();
            $display("FAIL R1: %0d expected items never compared, expected 0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1: watchdog expired at cycle %0d, expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule